// File: doc/BRIEF.md
# Channel Status Capture and CRC Check

This block gathers the channel status bit carried by every subframe of a digital audio stream and rebuilds the full status block twice over: once from subframe 1 and once from subframe 2. A block-start strobe marks frame 0 of each block. When a block has been received in full and the next block starts, the finished block is latched as one unit. The CRC byte is checked for professional-format blocks at that moment.

A small parallel view shows a few status fields for one channel. The meaning of those fields depends on the professional/consumer bit of the latched block. An enable input freezes the view. A separate error flag for the chosen channel is always live. That flag also trips when block starts arrive at the wrong spacing, which exposes edits that drop samples.

Top module: `cs_status_rx`

## Requirements
- R1: After reset, `fmt_o`, `fld_o` and `crc_err_o` are all 0 and the latched blocks are all zeros.
- R2: Each channel's bit from frame k after a block start is stored at bit index k (byte k/8, bit k%8, LSB first). A block is latched at the next accepted block start only when exactly `BLK_FRAMES` frames have passed. The view changes one cycle after that start.
- R3: `fmt_o` is the inverse of latched bit 0 of the viewed channel: 0 means professional (bit 0 = 1) and 1 means consumer.
- R4: In professional format, `fld_o[0]` is the channel's CRC error flag, `fld_o[1]` is bit 2, `fld_o[2]` is bit 3, `fld_o[3]` is bit 1 and `fld_o[4]` is bit 9.
- R5: In consumer format, `fld_o[0]` is 1 when bits 8 to 14 are all zero (general category, so the category is ignored), `fld_o[1]` is bit 15 (generation status), and `fld_o[4:2]` carry bits 3, 2 and 1.
- R6: `ch_sel` = 0 views subframe 1 and `ch_sel` = 1 views subframe 2 while `sel` is high. While `sel` is low, `fmt_o` and `fld_o` hold their values.
- R7: At a complete block start, a channel's flag becomes 1 only if its block is professional and the CRC-8 over bits 0 to N-9 does not match the last byte. The CRC uses polynomial 0x1D, initial value 0xFF and bits fed in index order, and CRC bit j is compared with block bit N-8+j. Consumer blocks clear the flag. The flag changes only at block starts.
- R8: A block start that arrives other than exactly `BLK_FRAMES` frames after the previous one sets both channel flags and leaves the latched blocks unchanged.
- R9: `crc_err_o` shows the flag of the channel chosen by `ch_sel` one cycle later, whatever the state of `sel`.
- R10: The first block start after reset only aligns the frame count: it latches nothing and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c_stb | input | 1 | Status bit valid, one per subframe |
| c_sub | input | 1 | Subframe identity of the bit (0 = subframe 1, 1 = subframe 2) |
| c_bit | input | 1 | Channel status bit |
| blk_start | input | 1 | Marks frame 0; honoured only with a subframe 1 strobe |
| sel | input | 1 | View enable |
| ch_sel | input | 1 | Viewed channel |
| fmt_o | output | 1 | Format indicator (0 professional, 1 consumer) |
| fld_o | output | 5 | Format-dependent status fields |
| crc_err_o | output | 1 | CRC or block alignment error of the viewed channel |

## Verification
The bench builds the block with the default `BLK_FRAMES` of 192. This exercises the real 23-byte CRC span and the real check-byte position. Blocks of 192 frames alternate with one short block of 100 frames, so the complete, misaligned and first-start paths are all reached. Known-good and deliberately corrupted check bytes are sent in both formats on both channels.

// File: rtl/cs_pkg.sv
package cs_pkg;

  // one serial CRC-8 step, polynomial x^8+x^4+x^3+x^2+1
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
    logic fb;
    fb = c[7] ^ b;
    return {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
  endfunction

  // {fmt, fld[4:0]} view from the low 16 status bits and the channel flag
  function automatic logic [5:0] status_view(input logic [15:0] lo, input logic flag);
    logic [4:0] f;
    if (lo[0]) f = {lo[9], lo[1], lo[3], lo[2], flag};
    else       f = {lo[3], lo[2], lo[1], lo[15], (lo[14:8] == 7'd0)};
    return {~lo[0], f};
  endfunction

endpackage

// File: rtl/cs_frame_ctr.sv
module cs_frame_ctr #(
  parameter int N  = 192,
  parameter int CW = $clog2(N + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          sub,
  input  logic          blk_start,
  output logic [CW-1:0] fpos,
  output logic [CW-1:0] wr_idx,
  output logic          wr_ok,
  output logic          blk_evt,
  output logic          complete,
  output logic          misalign
);
  localparam logic [CW-1:0] NV  = CW'(N);
  localparam logic [CW-1:0] SAT = CW'(N + 1);

  logic seen;

  assign blk_evt  = stb && !sub && blk_start;
  assign complete = blk_evt && seen && (fpos == NV);
  assign misalign = blk_evt && seen && (fpos != NV);
  assign wr_idx   = blk_evt ? '0 : fpos;
  assign wr_ok    = blk_evt || (fpos < NV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fpos <= SAT;
      seen <= 1'b0;
    end else begin
      if (blk_evt) begin
        fpos <= '0;
        seen <= 1'b1;
      end else if (stb && sub && fpos != SAT) begin
        fpos <= fpos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cs_chan_asm.sv
module cs_chan_asm #(
  parameter int N   = 192,
  parameter bit SUB = 1'b0,
  parameter int CW  = $clog2(N + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          sub,
  input  logic          c_bit,
  input  logic [CW-1:0] wr_idx,
  input  logic          wr_ok,
  input  logic          complete,
  input  logic          misalign,
  output logic [N-1:0]  blk_q,
  output logic          crc_flag,
  output logic          crc_bad
);
  localparam int SPAN = N - 8;

  logic [N-1:0] sreg;

  function automatic logic [7:0] crc_calc(input logic [SPAN-1:0] d);
    logic [7:0] c;
    c = 8'hFF;
    for (int i = 0; i < SPAN; i++) c = cs_pkg::crc8_step(c, d[i]);
    return c;
  endfunction

  assign crc_bad = sreg[0] && (crc_calc(sreg[SPAN-1:0]) != sreg[N-1:SPAN]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg     <= '0;
      blk_q    <= '0;
      crc_flag <= 1'b0;
    end else begin
      if (stb && (sub == SUB) && wr_ok) sreg[wr_idx] <= c_bit;
      if (misalign) begin
        crc_flag <= 1'b1;
      end else if (complete) begin
        blk_q    <= sreg;
        crc_flag <= crc_bad;
      end
    end
  end
endmodule

// File: rtl/cs_status_rx.sv
module cs_status_rx #(
  parameter int BLK_FRAMES = 192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       c_stb,
  input  logic       c_sub,
  input  logic       c_bit,
  input  logic       blk_start,
  input  logic       sel,
  input  logic       ch_sel,
  output logic       fmt_o,
  output logic [4:0] fld_o,
  output logic       crc_err_o
);
  localparam int CW = $clog2(BLK_FRAMES + 2);

  logic [CW-1:0]         fpos, wr_idx;
  logic                  wr_ok, blk_evt, complete, misalign;
  logic [BLK_FRAMES-1:0] blk_q [2];
  logic [1:0]            crc_flag, crc_bad;
  logic [BLK_FRAMES-1:0] blk_q0, blk_q1;
  logic [5:0]            view;

  cs_frame_ctr #(.N(BLK_FRAMES), .CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .stb(c_stb), .sub(c_sub), .blk_start(blk_start),
    .fpos(fpos), .wr_idx(wr_idx), .wr_ok(wr_ok), .blk_evt(blk_evt),
    .complete(complete), .misalign(misalign)
  );

  for (genvar gi = 0; gi < 2; gi++) begin : g_ch
    cs_chan_asm #(.N(BLK_FRAMES), .SUB(gi == 1), .CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .stb(c_stb), .sub(c_sub), .c_bit(c_bit),
      .wr_idx(wr_idx), .wr_ok(wr_ok), .complete(complete), .misalign(misalign),
      .blk_q(blk_q[gi]), .crc_flag(crc_flag[gi]), .crc_bad(crc_bad[gi])
    );
  end

  assign blk_q0 = blk_q[0];
  assign blk_q1 = blk_q[1];
  assign view   = cs_pkg::status_view(ch_sel ? blk_q1[15:0] : blk_q0[15:0],
                                      crc_flag[ch_sel]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_o     <= 1'b0;
      fld_o     <= '0;
      crc_err_o <= 1'b0;
    end else begin
      crc_err_o <= crc_flag[ch_sel];
      if (sel) {fmt_o, fld_o} <= view;
    end
  end
endmodule

// File: rtl/cs_status_rx_chk.sv
module cs_status_rx_chk #(
  parameter int N  = 192,
  parameter int CW = $clog2(N + 2)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel,
  input logic          ch_sel,
  input logic          blk_evt,
  input logic          complete,
  input logic          misalign,
  input logic [CW-1:0] fpos,
  input logic [1:0]    crc_flag,
  input logic [N-1:0]  blk_q0,
  input logic [N-1:0]  blk_q1,
  input logic          fmt_o,
  input logic [4:0]    fld_o
);
  p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !complete |=> ($stable(blk_q0) && $stable(blk_q1)));

  p_count_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    blk_evt |=> (fpos == '0));

  p_pro_crc_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !ch_sel && blk_q0[0]) |=> (!fmt_o && fld_o[0] == $past(crc_flag[0])));

  p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ($stable(fmt_o) && $stable(fld_o)));

  p_flag_at_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_evt |=> $stable(crc_flag));

  p_misalign_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |=> (crc_flag == 2'b11));
endmodule

bind cs_status_rx cs_status_rx_chk #(.N(BLK_FRAMES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .ch_sel(ch_sel), .blk_evt(blk_evt),
  .complete(complete), .misalign(misalign), .fpos(fpos), .crc_flag(crc_flag),
  .blk_q0(blk_q0), .blk_q1(blk_q1), .fmt_o(fmt_o), .fld_o(fld_o)
);

// File: tb/cs_status_rx_test.sv
module cs_status_rx_test;
  localparam int N = 192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic c_stb = 1'b0, c_sub = 1'b0, c_bit = 1'b0, blk_start = 1'b0;
  logic sel = 1'b0, ch_sel = 1'b0;
  logic fmt_o, crc_err_o;
  logic [4:0] fld_o;

  always #5 clk = ~clk;

  cs_status_rx #(.BLK_FRAMES(N)) uut (
    .clk(clk), .rst_n(rst_n), .c_stb(c_stb), .c_sub(c_sub), .c_bit(c_bit),
    .blk_start(blk_start), .sel(sel), .ch_sel(ch_sel),
    .fmt_o(fmt_o), .fld_o(fld_o), .crc_err_o(crc_err_o)
  );

  typedef struct {
    string      tag;
    logic [5:0] view;
    logic       err;
  } exp_t;

  exp_t sbq[$];
  int   n_run = 0, n_fail = 0;

  // model state
  logic [N-1:0] m_lat [2];
  logic [1:0]   m_flag = 2'b00;
  bit           m_seen = 1'b0;
  int           m_len  = 0;

  function automatic logic [7:0] model_crc(input logic [N-1:0] b);
    logic [7:0] r = 8'hFF;
    for (int by = 0; by < N/8 - 1; by++)
      for (int k = 0; k < 8; k++) begin
        logic top;
        top = r[7] ^ b[8*by + k];
        r = r << 1;
        if (top) r = r ^ 8'h1D;
      end
    return r;
  endfunction

  function automatic logic [N-1:0] seal(input logic [N-1:0] b);
    logic [7:0]   c;
    logic [N-1:0] o;
    o = b;
    c = model_crc(b);
    for (int k = 0; k < 8; k++) o[N-8+k] = c[k];
    return o;
  endfunction

  function automatic logic [5:0] model_view(input logic [N-1:0] b, input logic f);
    logic [5:0] v;
    if (b[0] == 1'b1) begin
      v[5] = 1'b0; v[0] = f; v[1] = b[2]; v[2] = b[3]; v[3] = b[1]; v[4] = b[9];
    end else begin
      v[5] = 1'b1; v[0] = (b[14:8] == 7'h00); v[1] = b[15];
      v[2] = b[1]; v[3] = b[2]; v[4] = b[3];
    end
    return v;
  endfunction

  function automatic logic [N-1:0] fill(input logic [31:0] seed);
    logic [N-1:0] b;
    logic [31:0]  s = seed;
    for (int w = 0; w < N/32; w++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      b[32*w +: 32] = s;
    end
    return b;
  endfunction

  task automatic send_block(input logic [N-1:0] b1, input logic [N-1:0] b2, input int n);
    if (m_seen) begin
      if (m_len == N) begin
        for (int c = 0; c < 2; c++) begin
          logic [N-1:0] bb;
          bb = (c == 0) ? uut_in_b1 : uut_in_b2;
          m_lat[c]  = bb;
          m_flag[c] = bb[0] && (model_crc(bb) != bb[N-1:N-8]);
        end
      end else begin
        m_flag = 2'b11;
      end
    end
    m_seen = 1'b1;
    m_len  = n;
    uut_in_b1 = b1;
    uut_in_b2 = b2;
    for (int f = 0; f < n; f++) begin
      @(negedge clk);
      c_stb = 1'b1; c_sub = 1'b0; c_bit = b1[f]; blk_start = (f == 0);
      @(negedge clk);
      c_sub = 1'b1; c_bit = b2[f]; blk_start = 1'b0;
    end
    @(negedge clk);
    c_stb = 1'b0; c_sub = 1'b0; c_bit = 1'b0;
  endtask

  logic [N-1:0] uut_in_b1, uut_in_b2;

  // driver side: set the view controls, let two edges pass, push expectation
  task automatic look(input string tag, input logic s, input logic ch,
                      input logic [5:0] held);
    exp_t e;
    @(negedge clk);
    sel = s; ch_sel = ch;
    repeat (2) @(negedge clk);
    e.tag  = tag;
    e.view = s ? model_view(m_lat[ch], m_flag[ch]) : held;
    e.err  = m_flag[ch];
    sbq.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() != 0) begin
        exp_t e;
        e = sbq.pop_front();
        n_run++;
        if (fmt_o !== e.view[5]) begin
          n_fail++;
          $display("FAIL %s fmt_o actual=%b expected=%b", e.tag, fmt_o, e.view[5]);
        end
        n_run++;
        if (fld_o !== e.view[4:0]) begin
          n_fail++;
          $display("FAIL %s fld_o actual=%b expected=%b", e.tag, fld_o, e.view[4:0]);
        end
        n_run++;
        if (crc_err_o !== e.err) begin
          n_fail++;
          $display("FAIL %s crc_err_o actual=%b expected=%b", e.tag, crc_err_o, e.err);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] a1, a2, b1, b2, c1, c2, d1, d2, e1, e2, s1;
    logic [5:0]   held;
    m_lat[0] = '0; m_lat[1] = '0;
    uut_in_b1 = '0; uut_in_b2 = '0;

    // A: ch1 professional good CRC, ch2 consumer general category
    a1 = fill(32'h1234_5678); a1[0] = 1'b1; a1[1] = 1'b1; a1[2] = 1'b0;
    a1[3] = 1'b1; a1[9] = 1'b1; a1 = seal(a1);
    a2 = fill(32'h0BAD_F00D); a2[0] = 1'b0; a2[14:8] = 7'h00; a2[15] = 1'b1;
    a2[1] = 1'b1; a2[2] = 1'b0; a2[3] = 1'b1;
    // B: ch1 professional bad CRC, ch2 professional good CRC
    b1 = fill(32'h5555_AAAA); b1[0] = 1'b1; b1[2] = 1'b1; b1[9] = 1'b0;
    b1 = seal(b1); b1[N-8] = ~b1[N-8];
    b2 = fill(32'h7777_1111); b2[0] = 1'b1; b2 = seal(b2);
    // C: ch1 consumer with a wrong check byte, ch2 professional good
    c1 = fill(32'h2468_ACE0); c1[0] = 1'b0; c1[14:8] = 7'h21;
    c1 = seal(c1); c1[N-1] = ~c1[N-1];
    c2 = fill(32'h1357_9BDF); c2[0] = 1'b1; c2 = seal(c2);
    s1 = fill(32'hCAFE_0001);
    d1 = fill(32'h0F0F_3C3C); d1[0] = 1'b1; d1 = seal(d1);
    d2 = fill(32'h9999_0000); d2[0] = 1'b0;
    e1 = fill(32'h4444_2222);
    e2 = fill(32'h6666_8888);

    repeat (3) @(negedge clk);
    sbq.push_back('{tag: "R1 reset", view: 6'b000000, err: 1'b0});
    rst_n = 1'b1;

    send_block(a1, a2, N);
    look("R10 first start latches nothing", 1'b1, 1'b0, 6'b0);

    send_block(b1, b2, N);
    look("R2 R3 R4 professional view ch1", 1'b1, 1'b0, 6'b0);
    look("R5 R6 consumer view ch2", 1'b1, 1'b1, 6'b0);

    send_block(c1, c2, N);
    look("R7 bad CRC ch1", 1'b1, 1'b0, 6'b0);
    look("R7 good CRC ch2", 1'b1, 1'b1, 6'b0);
    held = model_view(m_lat[1], m_flag[1]);
    look("R6 R9 hold with sel low, flag follows ch_sel", 1'b0, 1'b0, held);

    send_block(s1, s1, 100);
    look("R7 consumer ignores CRC ch1", 1'b1, 1'b0, 6'b0);
    look("R7 R2 professional ch2", 1'b1, 1'b1, 6'b0);

    send_block(d1, d2, N);
    look("R8 misaligned start ch1", 1'b1, 1'b0, 6'b0);
    look("R8 misaligned start ch2", 1'b1, 1'b1, 6'b0);

    send_block(e1, e2, N);
    look("R2 realigned block ch1", 1'b1, 1'b0, 6'b0);
    look("R5 realigned consumer ch2", 1'b1, 1'b1, 6'b0);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule